// File: doc/BRIEF.md
# Byte-Serial Big-Endian Load/Store Sequencer

This block carries out the memory half of load and store instructions for a processor whose data memory is only one byte wide. A request names two 32-bit register values, whose sum is the effective address, a transfer size (one byte or one 32-bit word), a direction, and for stores the 32-bit source value. The sequencer then drives the byte-wide memory port for as many cycles as the size needs. A word takes four single-byte accesses at consecutive addresses, with the most significant byte at the lowest address.

Loads use a memory with one cycle of read latency. Each returned byte is shifted into an assembly register, and the finished value appears on the load data output together with a one-cycle done pulse. A byte load zero-extends its byte to 32 bits. A byte store writes only the low eight bits of the source value. While an access is in progress the unit reports busy, and it ignores any new request.

Top module: `byte_serial_lsu`

## Requirements
- R1: The effective address is opa_i + opb_i taken modulo 2^32. Byte k of a word access (k = 0..3) uses address base + k, which also wraps modulo 2^32.
- R2: A word store (size_word_i=1, write_i=1) makes four writes in consecutive cycles at base, base+1, base+2 and base+3. The data written are wdata_i[31:24], [23:16], [15:8] and [7:0], in that order.
- R3: A byte store (size_word_i=0, write_i=1) makes exactly one write, of wdata_i[7:0], at the base address.
- R4: A word load returns a big-endian word: the byte at base goes to rdata_o[31:24] and the byte at base+3 goes to rdata_o[7:0].
- R5: A byte load returns the byte at base in rdata_o[7:0], with rdata_o[31:8] = 0.
- R6: Take the rising edge that accepts start_i as edge 0. done_o is then high in cycle 2 for a byte store, cycle 5 for a word store, cycle 3 for a byte load and cycle 6 for a word load.
- R7: done_o is high for exactly one cycle per accepted request. rdata_o changes only at the edge that raises done_o for a load, and holds its value at all other times.
- R8: A start_i that arrives while busy_o is high is ignored. It causes no memory write and no extra done pulse, and it does not change the access already in progress.
- R9: While reset is asserted and after it is released, done_o, mem_we_o and busy_o are 0 and rdata_o is 0.
- R10: mem_we_o is high only while a store is issuing bytes, and it is never high during a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe, taken only when idle |
| size_word_i | input | 1 | 1 = 32-bit word, 0 = single byte |
| write_i | input | 1 | 1 = store, 0 = load |
| opa_i | input | 32 | First address operand |
| opb_i | input | 32 | Second address operand |
| wdata_i | input | 32 | Store source value |
| mem_addr_o | output | 32 | Byte address to memory |
| mem_wdata_o | output | 8 | Byte to write |
| mem_we_o | output | 1 | Memory write enable |
| mem_rdata_i | input | 8 | Read byte, valid one cycle after its address |
| rdata_o | output | 32 | Load result |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Access in progress |

## Verification
The checker assumes two things about its inputs. First, the memory really returns each read byte exactly one cycle after its address is presented. Second, a caller waits for done_o before it relies on rdata_o. The bench's memory model registers its read data on every rising edge, and it indexes by the low address byte, so the wraparound at 2^32 lands on real storage. Requests are driven on the falling edge and held for one cycle. The only exception is the scenario that deliberately raises start_i while busy_o is high.

// File: rtl/byte_serial_lsu.sv
module byte_serial_lsu #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          size_word_i,
  input  logic          write_i,
  input  logic [AW-1:0] opa_i,
  input  logic [AW-1:0] opb_i,
  input  logic [DW-1:0] wdata_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_wdata_o,
  output logic          mem_we_o,
  input  logic [7:0]    mem_rdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          done_o,
  output logic          busy_o
);
  localparam int NB = DW / 8;
  localparam int IW = (NB > 1) ? $clog2(NB) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(NB - 1);

  logic          act, wr, wd, pend, plast, done;
  logic [IW-1:0] idx;
  logic [AW-1:0] base;
  logic [DW-1:0] sdat, lacc, rdat;
  logic          at_last;
  logic          take;

  assign at_last     = wd ? (idx == LAST_IDX) : 1'b1;
  assign take        = start_i && !act && !pend;
  assign mem_addr_o  = base + AW'(idx);
  assign mem_we_o    = act && wr;
  assign mem_wdata_o = sdat[DW-1 -: 8];
  assign rdata_o     = rdat;
  assign done_o      = done;
  assign busy_o      = act || pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act   <= 1'b0;
      wr    <= 1'b0;
      wd    <= 1'b0;
      pend  <= 1'b0;
      plast <= 1'b0;
      done  <= 1'b0;
      idx   <= '0;
      base  <= '0;
      sdat  <= '0;
      lacc  <= '0;
      rdat  <= '0;
    end else begin
      pend  <= act && !wr;
      plast <= act && at_last;
      done  <= (act && wr && at_last) || (pend && plast);
      if (take) begin
        act  <= 1'b1;
        idx  <= '0;
        base <= opa_i + opb_i;
        wr   <= write_i;
        wd   <= size_word_i;
        sdat <= size_word_i ? wdata_i : {wdata_i[7:0], {(DW-8){1'b0}}};
      end else if (act) begin
        idx  <= idx + 1'b1;
        sdat <= {sdat[DW-9:0], 8'h00};
        if (at_last) act <= 1'b0;
      end
      if (pend) begin
        lacc <= {lacc[DW-9:0], mem_rdata_i};
        if (plast)
          rdat <= wd ? {lacc[DW-9:0], mem_rdata_i} : {{(DW-8){1'b0}}, mem_rdata_i};
      end
    end
  end
endmodule

module byte_serial_lsu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] mem_addr_o,
  input logic        mem_we_o,
  input logic [31:0] rdata_o,
  input logic        done_o,
  input logic        busy_o
);
  // R10
  we_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> busy_o);
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R7
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(rdata_o));
  // R1
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o == $past(mem_addr_o) + 32'd1));
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
endmodule

bind byte_serial_lsu byte_serial_lsu_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o),
  .rdata_o(rdata_o), .done_o(done_o), .busy_o(busy_o)
);

// File: tb/byte_serial_lsu_tb_top.sv
`timescale 1ns/1ps
module byte_serial_lsu_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, size_word_i = 1'b0, write_i = 1'b0;
  logic [31:0] opa_i = '0, opb_i = '0, wdata_i = '0;
  logic [31:0] mem_addr_o, rdata_o;
  logic [7:0]  mem_wdata_o;
  logic [7:0]  mem_rdata_i;
  logic        mem_we_o, done_o, busy_o;
  int tests = 0, fails = 0;
  int nwrites = 0;
  logic [31:0] last_waddr;
  logic [7:0]  mem [256];

  always #2 clk = ~clk;

  byte_serial_lsu dut_i (.*);

  always @(posedge clk) begin
    if (mem_we_o) begin
      mem[mem_addr_o[7:0]] <= mem_wdata_o;
      nwrites <= nwrites + 1;
      last_waddr <= mem_addr_o;
    end
    mem_rdata_i <= mem[mem_addr_o[7:0]];
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic w, input logic st, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] d, output int lat);
    @(negedge clk);
    start_i = 1'b1; size_word_i = w; write_i = st; opa_i = a; opb_i = b; wdata_i = d;
    @(negedge clk);
    start_i = 1'b0;
    lat = 1;
    while (!done_o && lat < 50) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic t_reset();
    check("R9 done", {31'b0, done_o}, 32'd0);
    check("R9 we", {31'b0, mem_we_o}, 32'd0);
    check("R9 busy", {31'b0, busy_o}, 32'd0);
    check("R9 rdata", rdata_o, 32'd0);
  endtask

  task automatic t_word_store();
    int lat, n0;
    n0 = nwrites;
    run_op(1'b1, 1'b1, 32'h0000_0010, 32'h0000_0020, 32'hA1B2C3D4, lat);
    check("R6 word store latency", lat, 5);
    @(negedge clk);
    check("R2 nwrites", nwrites - n0, 4);
    check("R2 byte0", {24'b0, mem[8'h30]}, 32'hA1);
    check("R2 byte1", {24'b0, mem[8'h31]}, 32'hB2);
    check("R2 byte2", {24'b0, mem[8'h32]}, 32'hC3);
    check("R2 byte3", {24'b0, mem[8'h33]}, 32'hD4);
  endtask

  task automatic t_byte_store();
    int lat, n0;
    n0 = nwrites;
    run_op(1'b0, 1'b1, 32'h0000_0040, 32'h0000_0005, 32'h1122_3344, lat);
    check("R6 byte store latency", lat, 2);
    @(negedge clk);
    check("R3 nwrites", nwrites - n0, 1);
    check("R3 data", {24'b0, mem[8'h45]}, 32'h44);
    check("R3 neighbour", {24'b0, mem[8'h46]}, 32'h46 * 7 + 3 & 32'hFF);
  endtask

  task automatic t_word_load();
    int lat, n0;
    n0 = nwrites;
    run_op(1'b1, 1'b0, 32'h0000_0028, 32'h0000_0008, 32'h0, lat);
    check("R6 word load latency", lat, 6);
    check("R4 word load", rdata_o, 32'hA1B2C3D4);
    check("R10 load writes", nwrites - n0, 0);
  endtask

  task automatic t_byte_load();
    int lat;
    run_op(1'b0, 1'b0, 32'h0000_0030, 32'h0000_0003, 32'h0, lat);
    check("R6 byte load latency", lat, 3);
    check("R5 zero extend", rdata_o, 32'h0000_00D4);
  endtask

  task automatic t_wrap();
    int lat;
    run_op(1'b1, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0102_0304, lat);
    @(negedge clk);
    check("R1 wrap last addr", last_waddr, 32'h0000_0001);
    check("R1 wrap FE", {24'b0, mem[8'hFE]}, 32'h01);
    check("R1 wrap 01", {24'b0, mem[8'h01]}, 32'h04);
    run_op(1'b1, 1'b0, 32'hFFFF_FFF0, 32'h0000_000E, 32'h0, lat);
    check("R1 wrap load", rdata_o, 32'h0102_0304);
  endtask

  task automatic t_busy_ignore();
    int lat, n0;
    logic [31:0] held;
    n0 = nwrites;
    @(negedge clk);
    start_i = 1'b1; size_word_i = 1'b1; write_i = 1'b0; opa_i = 32'h30; opb_i = 32'h0;
    @(negedge clk);
    held = rdata_o;
    start_i = 1'b1; size_word_i = 1'b0; write_i = 1'b1; opa_i = 32'h80; opb_i = 32'h0;
    wdata_i = 32'h0000_0055;
    @(negedge clk);
    start_i = 1'b0;
    check("R7 rdata held while busy", rdata_o, held);
    lat = 2;
    while (!done_o && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    check("R8 original latency", lat, 6);
    check("R8 original result", rdata_o, 32'hA1B2C3D4);
    @(negedge clk);
    check("R7 single pulse", {31'b0, done_o}, 32'd0);
    repeat (6) begin
      @(negedge clk);
      if (done_o) check("R8 extra done", 32'd1, 32'd0);
    end
    check("R8 no write", nwrites - n0, 0);
    check("R8 target untouched", {24'b0, mem[8'h80]}, (32'h80 * 7 + 3) & 32'hFF);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 7 + 3) & 8'hFF);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_word_store();
    t_byte_store();
    t_word_load();
    t_byte_load();
    t_wrap();
    t_busy_ignore();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule